// File: doc/BRIEF.md
# Coincident-Current Core Plane

This block is a clocked behavioural model of a single plane of magnetic core storage. The cells form a grid addressed by a set of X drive lines and a set of Y drive lines. A cell is written only when its X line and its Y line are both driven in the same cycle. Each line carries half the current needed to switch a core, so a cell that sits on only one driven line keeps its state. A shared inhibit input cancels half the drive across the whole plane. A coincident-selected cell then keeps its old value too. This is how a word built from several planes writes a 0 into some bit positions.

The block has no read-data bus. A read drives the selected cell toward 0, and the result comes back on the sense output: a one-cycle pulse appears a fixed number of cycles later only if the cell actually changed state. A read therefore clears the cell it reads, and the caller restores the value with a write of the same polarity. The cell contents have no reset. Only the sense delay line and the error flag are cleared by the reset of the control logic. If more than one X line or more than one Y line is asserted in a cycle, the block changes no cell and raises an error flag.

Top module: `core_plane`

## Requirements
- R1: A drive with `drive_pol` = 1 on one X line and one Y line, with `inhibit` low, leaves the intersecting cell holding 1. A drive with `drive_pol` = 0 leaves it holding 0. The cell holds that value until the next effective drive of that cell.
- R2: A drive with an X line asserted and no Y line asserted, or a Y line asserted and no X line asserted, changes no cell.
- R3: With `inhibit` high, a drive on one X line and one Y line leaves the intersecting cell unchanged.
- R4: If more than one bit of `x_sel` or more than one bit of `y_sel` is set in a cycle, no cell changes.
- R5: The sense output pulses only for a drive that changes the stored value of a cell. Driving a cell toward the value it already holds gives no pulse.
- R6: For a drive sampled at clock edge N, `sense_pulse` is high for exactly one cycle: the cycle after edge N+SENSE_DLY-1. It is low in every other cycle that belongs to that drive.
- R7: Asserting `rst_n` low clears `sense_pulse` and `sel_err` but keeps the stored cell values.
- R8: `sel_err` is high in the cycle after an edge at which more than one X line or more than one Y line was asserted, and low after edges with legal selects.
- R9: A read, meaning a drive with `drive_pol` = 0, is destructive. It pulses the sense output when the cell held 1 and leaves the cell at 0, so a second read of the same cell gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the control logic; does not touch cell contents |
| x_sel | input | NX | One-hot X drive lines |
| y_sel | input | NY | One-hot Y drive lines |
| drive_pol | input | 1 | Drive direction: 1 writes a one, 0 drives toward zero (read) |
| inhibit | input | 1 | Plane-wide inhibit; cancels half of the drive |
| sense_pulse | output | 1 | One-cycle pulse, SENSE_DLY cycles after a drive that flipped a cell |
| sel_err | output | 1 | Registered flag for a cycle with more than one X or Y line asserted |

## Verification
The bench targets the cases where a wrong model would silently corrupt storage or invent a read result.

A half-selected cell is read back afterwards. A model that writes on a single line would then miss the expected pulse. Inhibited writes and multi-line selects are followed by a read of the same cell, which exposes any model that lets them through.

Repeated drives in the same direction check that only real flips pulse the sense output. Back-to-back reads expose a model that does not clear the cell when it reads it. A write followed by a reset and then a read shows whether the contents wrongly share the control reset. Every pulse is checked against the full window of cycles for its drive, so a delay that is one stage off is reported.

// File: rtl/core_plane_pkg.sv
package core_plane_pkg;

    typedef enum logic {
        DRV_ZERO = 1'b0,
        DRV_ONE  = 1'b1
    } drive_pol_e;

    typedef struct packed {
        logic any;
        logic multi;
    } line_stat_t;

endpackage

// File: rtl/core_line_decode.sv
module core_line_decode #(
    parameter int N  = 64,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  lines,
    output logic [IW-1:0] idx,
    output core_plane_pkg::line_stat_t stat
);
    logic [N-1:0] low_cleared;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (lines[i]) idx = IW'(i);
        end
        low_cleared = lines & (lines - N'(1));
        stat.any    = |lines;
        stat.multi  = |low_cleared;
    end
endmodule

// File: rtl/core_cell_array.sv
module core_cell_array #(
    parameter int NX = 64,
    parameter int NY = 64,
    parameter int XW = 6,
    parameter int YW = 6,
    localparam int NCELL = NX * NY,
    localparam int CW    = $clog2(NCELL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] x_idx,
    input  logic [YW-1:0] y_idx,
    input  logic          strobe,
    input  core_plane_pkg::drive_pol_e pol,
    output logic          flip
);
    logic [NCELL-1:0] mem_d, mem_q;
    logic [CW-1:0]    cidx;

    always_comb begin
        cidx  = CW'(y_idx) * CW'(NX) + CW'(x_idx);
        mem_d = mem_q;
        flip  = 1'b0;
        if (strobe) begin
            flip        = (mem_q[cidx] != pol);
            mem_d[cidx] = pol;
        end
    end

    // Cells model magnetised cores: no reset.
    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    // R1: after an effective drive the cell holds the drive polarity
    a_r1_cell_holds_pol: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (mem_q[$past(cidx)] == $past(pol)));
endmodule

// File: rtl/core_sense_line.sv
module core_sense_line #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flip_in,
    input  logic err_in,
    output logic sense_out,
    output logic err_out
);
    typedef struct packed {
        logic [DLY-1:0] sh;
        logic           err;
    } sense_st_t;

    sense_st_t st_d, st_q;

    always_comb begin
        st_d.sh  = (st_q.sh << 1) | DLY'(flip_in);
        st_d.err = err_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sense_out = st_q.sh[DLY-1];
    assign err_out   = st_q.err;
endmodule

// File: rtl/core_plane.sv
module core_plane #(
    parameter int NX       = 64,
    parameter int NY       = 64,
    parameter int SENSE_DLY = 2,
    localparam int XW = $clog2(NX),
    localparam int YW = $clog2(NY)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NX-1:0] x_sel,
    input  logic [NY-1:0] y_sel,
    input  logic          drive_pol,
    input  logic          inhibit,
    output logic          sense_pulse,
    output logic          sel_err
);
    import core_plane_pkg::*;

    logic [XW-1:0] x_idx;
    logic [YW-1:0] y_idx;
    line_stat_t    x_stat, y_stat;
    logic          strobe, bad_sel, flip;
    drive_pol_e    pol;

    core_line_decode #(.N(NX), .IW(XW)) u_xdec (.lines(x_sel), .idx(x_idx), .stat(x_stat));
    core_line_decode #(.N(NY), .IW(YW)) u_ydec (.lines(y_sel), .idx(y_idx), .stat(y_stat));

    always_comb begin
        bad_sel = x_stat.multi | y_stat.multi;
        strobe  = x_stat.any & y_stat.any & ~bad_sel & ~inhibit;
        pol     = drive_pol ? DRV_ONE : DRV_ZERO;
    end

    core_cell_array #(.NX(NX), .NY(NY), .XW(XW), .YW(YW)) u_array (
        .clk(clk), .rst_n(rst_n), .x_idx(x_idx), .y_idx(y_idx),
        .strobe(strobe), .pol(pol), .flip(flip)
    );

    core_sense_line #(.DLY(SENSE_DLY)) u_sense (
        .clk(clk), .rst_n(rst_n), .flip_in(flip), .err_in(bad_sel),
        .sense_out(sense_pulse), .err_out(sel_err)
    );

    // R2: a single driven axis never flips a cell
    a_r2_half_select: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(x_sel) == 0 || $countones(y_sel) == 0) |-> !flip);
    // R3: inhibit blocks any flip
    a_r3_inhibit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> !flip);
    // R4: multi-line selects never flip a cell
    a_r4_multi_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(x_sel) > 1 || $countones(y_sel) > 1) |-> !flip);
    // R8: error flag follows an illegal select
    a_r8_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(x_sel) > 1 || $countones(y_sel) > 1) |=> sel_err);
endmodule

// File: tb/core_plane_bench.sv
module core_plane_bench;
    localparam int NX  = 64;
    localparam int NY  = 64;
    localparam int DLY = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NX-1:0] x_sel = '0;
    logic [NY-1:0] y_sel = '0;
    logic          drive_pol = 1'b0;
    logic          inhibit = 1'b0;
    logic          sense_pulse, sel_err;
    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;

    always #5ns clk = ~clk;

    core_plane #(.NX(NX), .NY(NY), .SENSE_DLY(DLY)) u_core_plane (
        .clk(clk), .rst_n(rst_n), .x_sel(x_sel), .y_sel(y_sel),
        .drive_pol(drive_pol), .inhibit(inhibit),
        .sense_pulse(sense_pulse), .sel_err(sel_err)
    );

    // {x[5:0], y[5:0], pol, inh, expect_pulse}
    localparam logic [14:0] VEC [12] = '{
        {6'd5,  6'd9,  1'b1, 1'b0, 1'b1},   // R1 write one
        {6'd5,  6'd9,  1'b1, 1'b0, 1'b0},   // R5 same value
        {6'd5,  6'd9,  1'b0, 1'b0, 1'b1},   // R9 read a one
        {6'd5,  6'd9,  1'b0, 1'b0, 1'b0},   // R9 second read
        {6'd5,  6'd9,  1'b1, 1'b1, 1'b0},   // R3 inhibited write
        {6'd5,  6'd9,  1'b0, 1'b0, 1'b0},   // R3 still zero
        {6'd63, 6'd63, 1'b1, 1'b0, 1'b1},   // R1 corner
        {6'd63, 6'd0,  1'b1, 1'b0, 1'b1},   // R1 corner
        {6'd63, 6'd63, 1'b0, 1'b0, 1'b1},   // R9 corner read
        {6'd63, 6'd0,  1'b1, 1'b0, 1'b0},   // R5 neighbour kept
        {6'd0,  6'd0,  1'b1, 1'b0, 1'b1},   // R1 origin
        {6'd0,  6'd0,  1'b0, 1'b0, 1'b1}    // R9 origin read
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic op(input logic [NX-1:0] xv, input logic [NY-1:0] yv,
                      input logic pol, input logic inh,
                      output logic [DLY:0] seen, output logic err1);
        @(negedge clk);
        x_sel = xv; y_sel = yv; drive_pol = pol; inhibit = inh;
        @(posedge clk);
        @(negedge clk);
        x_sel = '0; y_sel = '0; drive_pol = 1'b0; inhibit = 1'b0;
        seen[0] = sense_pulse;
        err1 = sel_err;
        for (int k = 1; k <= DLY; k++) begin
            @(negedge clk);
            seen[k] = sense_pulse;
        end
    endtask

    task automatic cell_op(input int x, input int y, input logic pol, input logic inh,
                           input bit exp_pulse, input string req, input bit chk);
        logic [DLY:0] seen;
        logic err1;
        logic [DLY:0] want;
        op(NX'(1) << x, NY'(1) << y, pol, inh, seen, err1);
        want = exp_pulse ? ((DLY+1)'(1) << (DLY-1)) : '0;
        if (chk) check(seen == want, req, int'(seen), int'(want));
    endtask

    initial begin
        #1ms;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DLY:0] seen;
        logic err1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sense_pulse == 1'b0, "R7 reset sense", int'(sense_pulse), 0);
        check(sel_err == 1'b0, "R7 reset err", int'(sel_err), 0);
        rst_n = 1'b1;

        // put cells used below into a known zero state
        cell_op(5, 9, 1'b0, 1'b0, 1'b0, "init", 1'b0);
        cell_op(63, 63, 1'b0, 1'b0, 1'b0, "init", 1'b0);
        cell_op(63, 0, 1'b0, 1'b0, 1'b0, "init", 1'b0);
        cell_op(0, 0, 1'b0, 1'b0, 1'b0, "init", 1'b0);

        // R6 timing is checked on every vector via the full window
        for (int i = 0; i < 12; i++) begin
            cell_op(int'(VEC[i][14:9]), int'(VEC[i][8:3]), VEC[i][2], VEC[i][1],
                    VEC[i][0], $sformatf("R6 vector %0d", i), 1'b1);
        end

        // R2: half selects do not disturb a stored one
        cell_op(5, 9, 1'b1, 1'b0, 1'b1, "R2 setup", 1'b1);
        op(NX'(1) << 5, '0, 1'b0, 1'b0, seen, err1);
        check(seen == '0, "R2 x only pulse", int'(seen), 0);
        op('0, NY'(1) << 9, 1'b0, 1'b0, seen, err1);
        check(seen == '0, "R2 y only pulse", int'(seen), 0);
        cell_op(5, 9, 1'b0, 1'b0, 1'b1, "R2 cell kept", 1'b1);

        // R4/R8: two X lines, then two Y lines
        op((NX'(1) << 5) | (NX'(1) << 6), NY'(1) << 9, 1'b1, 1'b0, seen, err1);
        check(err1 == 1'b1, "R8 multi x err", int'(err1), 1);
        check(seen == '0, "R4 multi x pulse", int'(seen), 0);
        op(NX'(1) << 5, (NY'(1) << 9) | (NY'(1) << 10), 1'b1, 1'b0, seen, err1);
        check(err1 == 1'b1, "R8 multi y err", int'(err1), 1);
        cell_op(5, 9, 1'b0, 1'b0, 1'b0, "R4 cell kept zero", 1'b1);
        op(NX'(1) << 5, NY'(1) << 9, 1'b0, 1'b0, seen, err1);
        check(err1 == 1'b0, "R8 legal no err", int'(err1), 0);

        // R7: contents survive reset
        cell_op(0, 0, 1'b1, 1'b0, 1'b1, "R7 write", 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(sense_pulse == 1'b0, "R7 sense in reset", int'(sense_pulse), 0);
        rst_n = 1'b1;
        cell_op(0, 0, 1'b0, 1'b0, 1'b1, "R7 kept after reset", 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule